// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block walks a chain of command blocks held in main memory and hands the payload of each block, one 32-bit word at a time, to a downstream command port. Every node begins with a header word. The header's low 24 bits point to the next node, and its top byte gives the number of payload words that directly follow the header. After a start pulse the walker reads a header and streams that header's payload. It then jumps to the pointer, and it stops once the pointer it is about to follow has bit 23 set.

While it walks, the block adds up an estimated cost of the transfer and shows the total when it finishes. A damaged list can form a ring. To catch this, the walker counts the nodes it visits. Once it passes a threshold it sets bit 23 in each header it visits, writing the header back to memory. When it later meets one of its own marks, it treats the mark as the end of the list. After such a walk it returns to the first marked node and follows the chain again, clearing every mark it set. Memory is left as it was found.

Memory access goes through one valid/ready request channel carrying reads and writes. Read data returns on a response strobe. Payload words leave on a valid/ready command channel.

Top module: `dmaChainWalker`

## Requirements
- R1: Only bits 23:0 of the start address are used. If bit 23 of the start address is set, no memory request is issued, `done` pulses on the next cycle, and `costOut` reads 0.
- R2: A node is fetched from byte address {current pointer bits 20:2, 2'b00} on the 21-bit memory address. Pointer bits 22:21 and 1:0 do not change which word is read.
- R3: In a header, bits 31:24 give the payload length L, from 0 to 255 words, and bits 23:0 give the next pointer.
- R4: The L payload words are read from the node address plus 4, 8, …, 4·L and are presented on the command port in that order. L = 0 sends nothing.
- R5: The walk ends after the node whose next pointer has bit 23 set. That node's payload is still sent.
- R6: For every visited node, `costOut` grows by 5 + L. It is cleared at start and holds its final value once `done` has pulsed.
- R7: Nodes are counted from zero. A visited node whose index is at least LOOP_LIMIT and whose header has bit 23 clear is written back with bit 23 set. No other write happens during the walk. A node with a genuine end marker is never written.
- R8: If any header was marked, the walker restarts at the first marked node and clears bit 23 of as many headers as it marked, following each cleared header's pointer. Afterwards memory matches its state before the walk.
- R9: `busy` is high from the cycle after an accepted start until the walk and any clean-up have finished. `done` pulses for one cycle as `busy` falls. A start pulse while busy is ignored.
- R10: A request or command word that is offered and not yet accepted keeps its valid, address, write flag and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begin a walk (ignored while busy) |
| startAddr | input | 32 | Address of the first node |
| busy | output | 1 | Walk or clean-up in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| costOut | output | COST_W | Accumulated cost estimate |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqAddr | output | MEM_AW | Byte address, word aligned |
| memReqWdata | output | 32 | Write data |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data |
| cmdValid | output | 1 | Command word valid |
| cmdReady | input | 1 | Command word accepted |
| cmdData | output | 32 | Payload word |

## Verification
The ring detector can act at the same moment the list ends. On a revisit, the read of a header carrying the walker's own mark is also the read that ends the walk. Separately, the node that reaches the marking threshold may be the node holding the genuine end marker. A single-node self-loop provokes the first case, and a chain exactly one node longer than the threshold provokes the second. Both are judged by the sent payload stream, the final cost, the number of memory writes (twice the marks, or none), and a word-for-word compare of memory against its pre-walk copy.

// File: rtl/dmaChainPkg.sv
package dmaChainPkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR_REQ, ST_HDR_WAIT, ST_DISPATCH, ST_MARK_WR,
    ST_PAY_REQ, ST_PAY_WAIT, ST_PAY_SEND, ST_NEXT,
    ST_CLN_REQ, ST_CLN_WAIT, ST_CLN_WR
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic takeHeader;
    logic markDone;
    logic takePayload;
    logic payloadSent;
    logic advance;
    logic loadClean;
    logic takeCleanHdr;
    logic cleanDone;
    logic selPay;
    logic selClean;
  } walkStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic startEnd;
    logic markPend;
    logic lenZero;
    logic lastPayload;
    logic nextEnd;
    logic anyMarked;
    logic lastClean;
  } walkFlags_t;

endpackage

// File: rtl/dmaChainDatapath.sv
module dmaChainDatapath
  import dmaChainPkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int PTR_W      = 24,
  parameter int MEM_AW     = 21,
  parameter int LEN_W      = 8,
  parameter int COST_W     = 32,
  parameter int LOOP_LIMIT = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       str,
  input  logic [WORD_W-1:0] startAddr,
  input  logic [WORD_W-1:0] memRspData,
  output walkFlags_t        flags,
  output logic [MEM_AW-1:0] memReqAddr,
  output logic [WORD_W-1:0] memReqWdata,
  output logic [WORD_W-1:0] cmdData,
  output logic [COST_W-1:0] costOut
);
  localparam int WIDX_W = MEM_AW - 2;
  localparam int NODE_W = $clog2(LOOP_LIMIT + 1) + 2;
  localparam int MARK_W = MEM_AW - 1;
  localparam int NODE_COST = 5;
  localparam logic [WORD_W-1:0] END_BIT = WORD_W'(1) << (PTR_W - 1);

  logic [WIDX_W-1:0] curWord, firstMark, cleanWord, payWord;
  logic [WORD_W-1:0] hdrReg, payData;
  logic [LEN_W-1:0]  payIdx, hdrLen;
  logic [COST_W-1:0] costAcc;
  logic [NODE_W-1:0] nodeIdx;
  logic [MARK_W-1:0] markCnt, cleanLeft;
  logic              markPend;
  logic              unusedBits;

  assign unusedBits = ^{startAddr[WORD_W-1:PTR_W], startAddr[PTR_W-2:MEM_AW], startAddr[1:0]};
  assign hdrLen  = hdrReg[WORD_W-1 -: LEN_W];
  assign payWord = curWord + WIDX_W'(payIdx) + WIDX_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWord   <= '0;
      hdrReg    <= '0;
      payData   <= '0;
      payIdx    <= '0;
      costAcc   <= '0;
      nodeIdx   <= '0;
      markCnt   <= '0;
      markPend  <= 1'b0;
      firstMark <= '0;
      cleanWord <= '0;
      cleanLeft <= '0;
    end else begin
      if (str.loadStart) begin
        curWord  <= startAddr[MEM_AW-1:2];
        costAcc  <= '0;
        nodeIdx  <= '0;
        markCnt  <= '0;
        markPend <= 1'b0;
      end
      if (str.takeHeader) begin
        hdrReg   <= memRspData;
        payIdx   <= '0;
        costAcc  <= costAcc + COST_W'(NODE_COST) + COST_W'(memRspData[WORD_W-1 -: LEN_W]);
        markPend <= (nodeIdx >= NODE_W'(LOOP_LIMIT)) && !memRspData[PTR_W-1];
        if (nodeIdx != '1) nodeIdx <= nodeIdx + 1'b1;
      end
      if (str.markDone) begin
        markCnt  <= markCnt + 1'b1;
        markPend <= 1'b0;
        if (markCnt == '0) firstMark <= curWord;
      end
      if (str.takePayload) payData <= memRspData;
      if (str.payloadSent) payIdx <= payIdx + 1'b1;
      if (str.advance) curWord <= hdrReg[MEM_AW-1:2];
      if (str.loadClean) begin
        cleanWord <= firstMark;
        cleanLeft <= markCnt;
      end
      if (str.takeCleanHdr) hdrReg <= memRspData;
      if (str.cleanDone) begin
        cleanWord <= hdrReg[MEM_AW-1:2];
        cleanLeft <= cleanLeft - 1'b1;
      end
    end
  end

  always_comb begin
    if (str.selClean)    memReqAddr = {cleanWord, 2'b00};
    else if (str.selPay) memReqAddr = {payWord, 2'b00};
    else                 memReqAddr = {curWord, 2'b00};
  end

  assign memReqWdata = str.selClean ? (hdrReg & ~END_BIT) : (hdrReg | END_BIT);
  assign cmdData     = payData;
  assign costOut     = costAcc;

  assign flags.startEnd    = startAddr[PTR_W-1];
  assign flags.markPend    = markPend;
  assign flags.lenZero     = (hdrLen == '0);
  assign flags.lastPayload = (({1'b0, payIdx} + 1'b1) == {1'b0, hdrLen});
  assign flags.nextEnd     = hdrReg[PTR_W-1];
  assign flags.anyMarked   = (markCnt != '0);
  assign flags.lastClean   = (cleanLeft == MARK_W'(1));

  AST_COST_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    str.takeHeader |=> costAcc > $past(costAcc)) else $error("cost did not grow"); // R6

  AST_MARK_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    str.markDone |=> !markPend) else $error("mark still pending"); // R7

endmodule

// File: rtl/dmaChainCtrl.sv
module dmaChainCtrl
  import dmaChainPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  walkFlags_t  flags,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        cmdReady,
  output walkStrobe_t str,
  output logic        busy,
  output logic        done,
  output logic        memReqValid,
  output logic        memReqWrite,
  output logic        cmdValid
);
  walkState_t state, nxt;
  logic finish;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= finish;
    end
  end

  always_comb begin
    nxt         = state;
    str         = '0;
    finish      = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    cmdValid    = 1'b0;
    case (state)
      ST_IDLE: if (startPulse) begin
        str.loadStart = 1'b1;
        if (flags.startEnd) finish = 1'b1;
        else                nxt = ST_HDR_REQ;
      end
      ST_HDR_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nxt = ST_HDR_WAIT;
      end
      ST_HDR_WAIT: if (memRspValid) begin
        str.takeHeader = 1'b1;
        nxt = ST_DISPATCH;
      end
      ST_DISPATCH: begin
        if (flags.markPend)     nxt = ST_MARK_WR;
        else if (flags.lenZero) nxt = ST_NEXT;
        else                    nxt = ST_PAY_REQ;
      end
      ST_MARK_WR: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          str.markDone = 1'b1;
          nxt = flags.lenZero ? ST_NEXT : ST_PAY_REQ;
        end
      end
      ST_PAY_REQ: begin
        str.selPay  = 1'b1;
        memReqValid = 1'b1;
        if (memReqReady) nxt = ST_PAY_WAIT;
      end
      ST_PAY_WAIT: if (memRspValid) begin
        str.takePayload = 1'b1;
        nxt = ST_PAY_SEND;
      end
      ST_PAY_SEND: begin
        cmdValid = 1'b1;
        if (cmdReady) begin
          str.payloadSent = 1'b1;
          nxt = flags.lastPayload ? ST_NEXT : ST_PAY_REQ;
        end
      end
      ST_NEXT: begin
        str.advance = 1'b1;
        if (!flags.nextEnd) nxt = ST_HDR_REQ;
        else if (flags.anyMarked) begin
          str.loadClean = 1'b1;
          nxt = ST_CLN_REQ;
        end else begin
          finish = 1'b1;
          nxt = ST_IDLE;
        end
      end
      ST_CLN_REQ: begin
        str.selClean = 1'b1;
        memReqValid  = 1'b1;
        if (memReqReady) nxt = ST_CLN_WAIT;
      end
      ST_CLN_WAIT: if (memRspValid) begin
        str.takeCleanHdr = 1'b1;
        nxt = ST_CLN_WR;
      end
      ST_CLN_WR: begin
        str.selClean = 1'b1;
        memReqValid  = 1'b1;
        memReqWrite  = 1'b1;
        if (memReqReady) begin
          str.cleanDone = 1'b1;
          if (flags.lastClean) begin
            finish = 1'b1;
            nxt = ST_IDLE;
          end else nxt = ST_CLN_REQ;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy) else $error("done while busy"); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid && !cmdValid) else $error("traffic while idle"); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid) else $error("request dropped"); // R10

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid) else $error("command dropped"); // R10

endmodule

// File: rtl/dmaChainWalker.sv
module dmaChainWalker
  import dmaChainPkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int PTR_W      = 24,
  parameter int MEM_AW     = 21,
  parameter int LEN_W      = 8,
  parameter int COST_W     = 32,
  parameter int LOOP_LIMIT = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [WORD_W-1:0] startAddr,
  output logic              busy,
  output logic              done,
  output logic [COST_W-1:0] costOut,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [MEM_AW-1:0] memReqAddr,
  output logic [WORD_W-1:0] memReqWdata,
  input  logic              memRspValid,
  input  logic [WORD_W-1:0] memRspData,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [WORD_W-1:0] cmdData
);
  walkStrobe_t str;
  walkFlags_t  flags;

  dmaChainCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .flags(flags),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .cmdReady(cmdReady),
    .str(str), .busy(busy), .done(done), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .cmdValid(cmdValid)
  );

  dmaChainDatapath #(
    .WORD_W(WORD_W), .PTR_W(PTR_W), .MEM_AW(MEM_AW), .LEN_W(LEN_W),
    .COST_W(COST_W), .LOOP_LIMIT(LOOP_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .startAddr(startAddr),
    .memRspData(memRspData), .flags(flags), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .cmdData(cmdData), .costOut(costOut)
  );

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr) && $stable(memReqWrite) && $stable(memReqWdata))
    else $error("request changed while stalled"); // R10

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> $stable(cmdData)) else $error("command data changed"); // R10

endmodule

// File: tb/dmaChainWalker_tb.sv
module dmaChainWalker_tb;
  localparam int TB_LIMIT = 32;
  localparam int MW = 2048;
  localparam int NV = 7;
  localparam logic [31:0] V_BASE [NV] = '{32'h000, 32'h100, 32'h400, 32'h800, 32'h800, 32'h000, 32'h200};
  localparam int          V_NODE [NV] = '{1, 5, 8, 32, 33, 4, 1};
  localparam int          V_MOD  [NV] = '{1, 4, 6, 3, 3, 3, 4};
  localparam int          V_RING [NV] = '{0, 0, 0, 0, 0, 1, 1};
  localparam logic [31:0] V_HI   [NV] = '{32'h0, 32'hAB00_0000, 32'h0060_0003, 32'h0, 32'h0, 32'h0, 32'h0};

  logic clk = 0, rstN = 0, startPulse = 0;
  logic [31:0] startAddr = 0;
  logic busy, done, memReqValid, memReqWrite, memRspValid, cmdValid;
  logic memReqReady, cmdReady;
  logic [31:0] costOut, memReqWdata, memRspData, cmdData;
  logic [20:0] memReqAddr;

  always #2.5 clk = ~clk;

  dmaChainWalker #(.LOOP_LIMIT(TB_LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startAddr(startAddr),
    .busy(busy), .done(done), .costOut(costOut),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData)
  );

  logic [31:0] mem [MW];
  logic [31:0] orig [MW];
  logic [31:0] shadow [MW];
  logic [31:0] got [MW];
  logic [31:0] expd [MW];
  logic hostWe = 0, cntClr = 0;
  logic [10:0] hostIdx = 0;
  logic [31:0] hostData = 0;
  int rdCnt, wrCnt, gotCnt, doneCnt;
  logic [15:0] lfsr = 16'hACE1;

  // memory model, command sink and counters
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (hostWe) mem[hostIdx] <= hostData;
    if (cntClr) begin
      rdCnt <= 0; wrCnt <= 0; gotCnt <= 0; doneCnt <= 0;
    end else begin
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          mem[memReqAddr[12:2]] <= memReqWdata;
          wrCnt <= wrCnt + 1;
        end else begin
          memRspValid <= 1'b1;
          memRspData  <= mem[memReqAddr[12:2]];
          rdCnt <= rdCnt + 1;
        end
      end
      if (cmdValid && cmdReady) begin
        got[gotCnt[10:0]] <= cmdData;
        gotCnt <= gotCnt + 1;
      end
      if (done) doneCnt <= doneCnt + 1;
    end
  end

  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign memReqReady = lfsr[0] | lfsr[3];
  assign cmdReady    = lfsr[5] | lfsr[1];

  int checks = 0, failures = 0;
  bit hung = 0;
  int expCnt, expMarks;
  longint expCost;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input int idx, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1; hostIdx = idx[10:0]; hostData = d;
    @(negedge clk);
    hostWe = 0;
  endtask

  // header: [31:24] length, [23:0] next pointer (R3)
  task automatic buildChain(input int v);
    for (int i = 0; i < V_NODE[v]; i++) begin
      int node = V_BASE[v] + i * 32;
      int len = (i + 1) % V_MOD[v];
      logic [23:0] nxt;
      if (i < V_NODE[v] - 1) nxt = 24'(V_BASE[v] + (i + 1) * 32) | (V_HI[v][23:0] & 24'h600003);
      else if (V_RING[v] != 0) nxt = 24'(V_BASE[v] + ((V_NODE[v] > 1) ? 32 : 0));
      else nxt = 24'h800ABC;
      hostWrite(node / 4, {8'(len), nxt});
      for (int k = 1; k <= len; k++)
        hostWrite(node / 4 + k, {4'hC, V_BASE[v][11:0], 8'(i), 8'(k)});
    end
  endtask

  // reference walk from the requirements, on a shadow copy
  task automatic refWalk(input logic [31:0] s);
    logic [23:0] a = s[23:0];
    int idx = 0;
    expCnt = 0; expCost = 0; expMarks = 0;
    for (int i = 0; i < MW; i++) begin shadow[i] = mem[i]; orig[i] = mem[i]; end
    while (!a[23] && idx < 100000) begin
      int w = int'(a[12:2]);
      logic [31:0] h = shadow[w];
      int len = int'(h[31:24]);
      expCost += 5 + len;
      for (int k = 1; k <= len; k++) begin
        expd[expCnt] = shadow[(w + k) % MW];
        expCnt++;
      end
      if (idx >= TB_LIMIT && !h[23]) begin
        shadow[w] = h | 32'h0080_0000;
        expMarks++;
      end
      idx++;
      a = h[23:0];
    end
  endtask

  task automatic runWalk(input logic [31:0] s, input string name);
    int guard = 0;
    int firstBad = -1;
    bit memOk = 1;
    refWalk(s);
    @(negedge clk); cntClr = 1;
    @(negedge clk); cntClr = 0;
    startPulse = 1; startAddr = s;
    @(negedge clk); startPulse = 0;
    chk(busy == 1'b1, "R9", {name, " busy after start"}, busy, 1);
    repeat (6) @(negedge clk);
    if (busy) begin
      startPulse = 1; startAddr = 32'h0;
      @(negedge clk); startPulse = 0;
    end
    while (!(doneCnt > 0 && !busy) && guard < 40000) begin
      @(negedge clk); guard++;
    end
    if (guard >= 40000) begin
      hung = 1;
      chk(0, "R9", {name, " watchdog"}, guard, 0);
      return;
    end
    @(negedge clk);
    chk(doneCnt == 1, "R9", {name, " single done pulse, restart ignored"}, doneCnt, 1);
    chk(costOut == 32'(expCost), "R6", {name, " cost"}, costOut, expCost);
    chk(gotCnt == expCnt, "R5", {name, " payload word count"}, gotCnt, expCnt);
    for (int i = 0; i < expCnt && i < MW; i++)
      if (firstBad < 0 && got[i] !== expd[i]) firstBad = i;
    chk(firstBad < 0, "R4", {name, " payload order (R3 fields)"},
        firstBad < 0 ? 0 : got[firstBad], firstBad < 0 ? 0 : expd[firstBad]);
    chk(wrCnt == 2 * expMarks, "R7", {name, " memory writes"}, wrCnt, 2 * expMarks);
    for (int i = 0; i < MW; i++) if (mem[i] !== orig[i]) memOk = 0;
    chk(memOk, "R8", {name, " memory restored"}, memOk, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memReqValid && !cmdValid, "R9", "reset outputs quiet",
        {busy, done, memReqValid, cmdValid}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !memReqValid && !cmdValid, "R10", "no requests after reset", {busy, memReqValid, cmdValid}, 0);

    // vector table: plain chains, aliased pointers (R1, R2), threshold edge and rings (R7, R8)
    for (int v = 0; v < NV && !hung; v++) begin
      buildChain(v);
      runWalk(V_BASE[v] | V_HI[v], $sformatf("vec%0d", v));
    end

    // R1: end marker in the start address
    if (!hung) begin
      @(negedge clk); cntClr = 1;
      @(negedge clk); cntClr = 0;
      startPulse = 1; startAddr = 32'h0080_0100;
      @(negedge clk); startPulse = 0;
      chk(done == 1'b1 && busy == 1'b0, "R1", "immediate done on marked start", {done, busy}, 2);
      @(negedge clk);
      chk(rdCnt == 0 && wrCnt == 0, "R1", "no memory traffic", rdCnt + wrCnt, 0);
      chk(costOut == 0, "R1", "cost zero (R6 cleared at start)", costOut, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule